// File: doc/BRIEF.md
# Supply Reset Supervisor

This block drives the active-low reset line that a regulated supply hands to the logic it powers. It watches digital fault indications from the power stage and holds the reset line low while any of them says the supply cannot be trusted. These are the filtered undervoltage and overvoltage comparator outputs, a thermal-shutdown flag, the enable pin, a bias-undervoltage flag and a soft-start-complete flag. When the last fault goes away, the line is not released at once. A release delay must run to its end first. This gives the downstream logic a clean reset pulse of known minimum length.

The two voltage comparators pass through deglitch filters. A filter changes its fault state only after its comparator has held the new level for a whole filter period, and it uses the same period to enter and to leave the fault. The enable pin is qualified by its own delay after it rises. The soft-start flag is handled apart from the other conditions. While soft start is still running it forces the line low, and once soft start completes the line is released with no added delay if everything else is already clear. An overvoltage fault also raises a switch-node shutdown request and a weak-pulldown request. All lengths are parameters counted in clock cycles.

Top module: `supply_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `rst_n_o`, `sw_off_o` and `pd_o` are all 0, and every counter starts from zero.
- R2: The undervoltage fault is set on the FILT_CYC-th consecutive clock edge at which `uv_cmp_i` is 1, and `rst_n_o` is 0 after that edge.
- R3: A comparator pulse (`uv_cmp_i` or `ov_cmp_i`) that lasts fewer than FILT_CYC edges restarts its filter count and leaves the fault state, `rst_n_o`, `sw_off_o` and `pd_o` unchanged.
- R4: A set undervoltage fault clears only on the FILT_CYC-th consecutive edge at which `uv_cmp_i` is 0.
- R5: An overvoltage fault is set and cleared with the same FILT_CYC filter as R2 and R4. While it is set, `sw_off_o` and `pd_o` are both 1 and `rst_n_o` is 0.
- R6: After every fault condition has ended, `rst_n_o` goes high on the REL_CYC-th clock edge, then stays high for as long as no condition returns.
- R7: If any fault condition returns while the release delay is running, the delay restarts from zero once the condition ends.
- R8: `rst_n_o` is 0 after any edge at which `tsd_i` or `bias_uv_i` is 1.
- R9: `rst_n_o` is 0 after any edge at which `en_i` is 0. The enable condition counts as cleared on the EN_CYC-th consecutive edge with `en_i` high, and the release delay of R6 starts after that edge.
- R10: While `ss_done_i` is 0, `rst_n_o` is 0 with no clock edge needed. When `ss_done_i` rises and the release delay has already expired, `rst_n_o` goes to 1 at once, with no new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for filters and delay counters |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_cmp_i | input | 1 | Undervoltage comparator output, hysteresis already applied (1 = below threshold) |
| ov_cmp_i | input | 1 | Overvoltage comparator output, hysteresis already applied (1 = above threshold) |
| tsd_i | input | 1 | Thermal-shutdown flag (1 = over temperature) |
| en_i | input | 1 | Enable pin (0 = disabled) |
| bias_uv_i | input | 1 | Bias supply undervoltage flag (1 = bias too low) |
| ss_done_i | input | 1 | Soft start complete (0 = soft start still running) |
| rst_n_o | output | 1 | Reset output, 0 = fault signalled |
| sw_off_o | output | 1 | Switch-node shutdown request during overvoltage |
| pd_o | output | 1 | Weak pulldown request during overvoltage |

## Verification
The hardest case to reach from the ports is a fault that returns partway through the release delay, because the delay itself is invisible: its count only shows when `rst_n_o` rises. The stimulus runs the delay for part of its length, pulses the thermal flag, and then checks that `rst_n_o` is still low one edge short of a full new delay and high exactly at the full delay. The no-delay release after soft start is reached in a similar way. The bench first lets the delay expire, then drops `ss_done_i`, and then raises it again, so the immediate release can be told apart from a late one.

// File: rtl/srst_pkg.sv
package srst_pkg;

   // Comparator channels that share the deglitch filter structure
   typedef enum int unsigned {
      CH_UV  = 0,
      CH_OV  = 1,
      NUM_CH = 2
   } srst_ch_e;

   // Counter width able to hold values 0 .. n-1, at least one bit
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/srst_deglitch.sv
module srst_deglitch #(
   parameter int unsigned FILT_CYC = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic flt_o
);
   localparam int unsigned CW = srst_pkg::cnt_width(FILT_CYC);
   localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

   logic flt_q;

   generate
      if (FILT_CYC <= 1) begin : g_direct
         // A one-cycle filter reduces to a plain register
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flt_q <= 1'b0;
            else         flt_q <= raw_i;
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (raw_i == flt_q) begin
               // Input agrees with the held state: any partial run is dropped
               run_q <= '0;
            end else if (run_q == LAST) begin
               flt_q <= raw_i;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign flt_o = flt_q;
endmodule

// File: rtl/srst_delay.sv
module srst_delay #(
   parameter int unsigned DLY_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic go_i,
   output logic done_o
);
   localparam int unsigned CW = srst_pkg::cnt_width(DLY_CYC);
   localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

   logic done_q;

   generate
      if (DLY_CYC <= 1) begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) done_q <= 1'b0;
            else         done_q <= go_i;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (!go_i) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               if (cnt_q == LAST) done_q <= 1'b1;
               else               cnt_q  <= cnt_q + 1'b1;
            end
            // once done the counter holds its terminal value
         end
      end
   endgenerate

   assign done_o = done_q;
endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl #(
   parameter int unsigned FILT_CYC = 4,
   parameter int unsigned EN_CYC   = 6,
   parameter int unsigned REL_CYC  = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic uv_cmp_i,
   input  logic ov_cmp_i,
   input  logic tsd_i,
   input  logic en_i,
   input  logic bias_uv_i,
   input  logic ss_done_i,
   output logic rst_n_o,
   output logic sw_off_o,
   output logic pd_o
);
   import srst_pkg::*;

   // Elaboration-time parameter checks
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("supply_reset_ctrl: FILT_CYC must be at least 1");
   end
   if (EN_CYC < 1) begin : g_bad_en
      $error("supply_reset_ctrl: EN_CYC must be at least 1");
   end
   if (REL_CYC < 1) begin : g_bad_rel
      $error("supply_reset_ctrl: REL_CYC must be at least 1");
   end

   logic [NUM_CH-1:0] cmp_raw;
   logic [NUM_CH-1:0] cmp_flt;
   logic              en_ok;
   logic              rel_done;
   logic              held_flt;
   logic              fault_any;

   assign cmp_raw[CH_UV] = uv_cmp_i;
   assign cmp_raw[CH_OV] = ov_cmp_i;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
      srst_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .raw_i (cmp_raw[ch]),
         .flt_o (cmp_flt[ch])
      );
   end

   // Enable must stay high for EN_CYC edges before it counts as cleared
   srst_delay #(.DLY_CYC(EN_CYC)) u_en_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .go_i  (en_i),
      .done_o(en_ok)
   );

   // Registered fault state, plus the raw flags that bypass filtering
   assign held_flt  = cmp_flt[CH_UV] | cmp_flt[CH_OV] | ~en_ok;
   assign fault_any = held_flt | tsd_i | bias_uv_i;

   srst_delay #(.DLY_CYC(REL_CYC)) u_release (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .go_i  (~fault_any),
      .done_o(rel_done)
   );

   // The soft-start lockout gates the output directly and needs no delay
   assign rst_n_o  = rel_done & ~held_flt & ss_done_i;
   assign sw_off_o = cmp_flt[CH_OV];
   assign pd_o     = cmp_flt[CH_OV];
endmodule

// File: rtl/srst_chk.sv
module srst_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic uv_cmp_i,
   input logic ov_cmp_i,
   input logic tsd_i,
   input logic en_i,
   input logic bias_uv_i,
   input logic ss_done_i,
   input logic rst_n_o,
   input logic sw_off_o,
   input logic pd_o
);
   p_in_reset_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (!rst_n_o && !sw_off_o && !pd_o));

   p_fall_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_n_o) |-> (!ss_done_i || $past(uv_cmp_i) || $past(ov_cmp_i)
                          || $past(tsd_i) || $past(bias_uv_i) || !$past(en_i)));

   p_ov_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_off_o) |-> $past(ov_cmp_i));

   p_ov_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_off_o) |-> !$past(ov_cmp_i));

   p_ov_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_off_o || pd_o) |-> !rst_n_o);

   p_rise_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_n_o) |-> (ss_done_i && !$past(tsd_i) && !$past(bias_uv_i)
                          && $past(en_i)));

   p_tsd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tsd_i |=> !rst_n_o);

   p_bias_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bias_uv_i |=> !rst_n_o);

   p_en_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !rst_n_o);

   p_ss_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ss_done_i |-> !rst_n_o);
endmodule

bind supply_reset_ctrl srst_chk u_chk (.*);

// File: tb/sim_supply_reset_ctrl.sv
module sim_supply_reset_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int FILT = 4;
   localparam int ENC  = 6;
   localparam int REL  = 8;
   localparam int WATCHDOG_CYC = 20000;
   localparam int NVEC = 29;

   // Vector: {uv,ov,tsd,en,bias,ss}[17:12], edges[11:6], {rst_n,sw}[5:4], req[3:0]
   localparam logic [17:0] VEC [NVEC] = '{
      {6'b000101, 6'd5, 2'b00, 4'd9},   // R9 enable qualifying
      {6'b000101, 6'd1, 2'b00, 4'd9},   // R9 enable now cleared
      {6'b000101, 6'd7, 2'b00, 4'd6},   // R6 one edge short of release
      {6'b000101, 6'd1, 2'b10, 4'd6},   // R6 released
      {6'b100101, 6'd3, 2'b10, 4'd3},   // R3 short UV pulse
      {6'b000101, 6'd1, 2'b10, 4'd3},
      {6'b100101, 6'd3, 2'b10, 4'd3},   // R3 count restarted
      {6'b100101, 6'd1, 2'b00, 4'd2},   // R2 UV fault on fourth edge
      {6'b000101, 6'd3, 2'b00, 4'd4},   // R4 still faulted
      {6'b000101, 6'd1, 2'b00, 4'd4},   // R4 fault cleared
      {6'b000101, 6'd7, 2'b00, 4'd6},
      {6'b000101, 6'd1, 2'b10, 4'd6},
      {6'b010101, 6'd4, 2'b01, 4'd5},   // R5 OV set
      {6'b000101, 6'd4, 2'b00, 4'd5},   // R5 OV cleared
      {6'b000101, 6'd8, 2'b10, 4'd6},
      {6'b001101, 6'd1, 2'b00, 4'd8},   // R8 thermal
      {6'b000101, 6'd5, 2'b00, 4'd7},   // R7 delay part run
      {6'b001101, 6'd1, 2'b00, 4'd7},   // R7 fault returns
      {6'b000101, 6'd7, 2'b00, 4'd7},   // R7 one short of full restart
      {6'b000101, 6'd1, 2'b10, 4'd7},
      {6'b000111, 6'd1, 2'b00, 4'd8},   // R8 bias
      {6'b000101, 6'd8, 2'b10, 4'd8},
      {6'b000100, 6'd1, 2'b00, 4'd10},  // R10 soft start lockout
      {6'b000101, 6'd1, 2'b10, 4'd10}   // R10 immediate release
      ,{6'b000001, 6'd1, 2'b00, 4'd9},  // R9 enable low
      {6'b000101, 6'd5, 2'b00, 4'd9},
      {6'b000101, 6'd1, 2'b00, 4'd9},
      {6'b000101, 6'd7, 2'b00, 4'd9},
      {6'b000101, 6'd1, 2'b10, 4'd9}
   };

   logic clk_i = 1'b0;
   logic rst_ni = 1'b0;
   logic uv_cmp_i = 1'b0, ov_cmp_i = 1'b0, tsd_i = 1'b0;
   logic en_i = 1'b1, bias_uv_i = 1'b0, ss_done_i = 1'b1;
   logic rst_n_o, sw_off_o, pd_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk_i = ~clk_i;

   supply_reset_ctrl #(.FILT_CYC(FILT), .EN_CYC(ENC), .REL_CYC(REL)) u0 (
      .clk_i(clk_i), .rst_ni(rst_ni), .uv_cmp_i(uv_cmp_i), .ov_cmp_i(ov_cmp_i),
      .tsd_i(tsd_i), .en_i(en_i), .bias_uv_i(bias_uv_i), .ss_done_i(ss_done_i),
      .rst_n_o(rst_n_o), .sw_off_o(sw_off_o), .pd_o(pd_o)
   );

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {rst_n,sw_off,pd} actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [5:0] in);
      {uv_cmp_i, ov_cmp_i, tsd_i, en_i, bias_uv_i, ss_done_i} = in;
   endtask

   task automatic run(input logic [5:0] in, input int n);
      apply(in);
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk_i);
      errors++;
      $display("FAIL watchdog expired, all requirements: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: state held in reset
      repeat (3) @(negedge clk_i);
      check("R1", {rst_n_o, sw_off_o, pd_o}, 3'b000);
      rst_ni = 1'b1;
      check("R1", {rst_n_o, sw_off_o, pd_o}, 3'b000);

      for (int i = 0; i < NVEC; i++) begin
         run(VEC[i][17:12], int'(VEC[i][11:6]));
         check($sformatf("R%0d vec %0d", VEC[i][3:0], i),
               {rst_n_o, sw_off_o, pd_o}, {VEC[i][5:4], VEC[i][4]});
      end

      // R3: short OV pulse leaves the OV outputs untouched
      run(6'b010101, FILT - 1);
      check("R3 ov pulse", {rst_n_o, sw_off_o, pd_o}, 3'b100);
      run(6'b000101, 1);
      check("R3 ov pulse after", {rst_n_o, sw_off_o, pd_o}, 3'b100);

      // R1: reset in the middle of an OV fault clears everything
      run(6'b010101, FILT);
      check("R5 ov set", {rst_n_o, sw_off_o, pd_o}, 3'b011);
      rst_ni = 1'b0;
      #1;
      check("R1 async", {rst_n_o, sw_off_o, pd_o}, 3'b000);
      apply(6'b000101);
      @(negedge clk_i);
      rst_ni = 1'b1;
      // R1 + R9 + R6: counters started from zero after reset
      run(6'b000101, ENC + REL - 1);
      check("R1 restart", {rst_n_o, sw_off_o, pd_o}, 3'b000);
      run(6'b000101, 1);
      check("R6 release after restart", {rst_n_o, sw_off_o, pd_o}, 3'b100);

      // R6: released output stays high over a long clean stretch
      run(6'b000101, 40);
      check("R6 hold", {rst_n_o, sw_off_o, pd_o}, 3'b100);

      // R10: lockout is combinational, no edge needed
      apply(6'b000100);
      #1;
      check("R10 comb low", {rst_n_o, sw_off_o, pd_o}, 3'b000);
      apply(6'b000101);
      #1;
      check("R10 comb high", {rst_n_o, sw_off_o, pd_o}, 3'b100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule